// File: doc/BRIEF.md
# Programmable Processor Clock Generator

This block makes the clock for an attached processor out of the system clock. Software writes a 3-bit divide select, which gives any integer ratio from 1 to 8. After reset the ratio is 8, the slowest setting, so the processor starts at low power. A new ratio never cuts into a period that has already started. It takes over when the current output period ends, so no short pulse reaches the processor.

The processor's bus timing has to stay in step with this clock. The processor echoes the clock it receives back to the block. When resynchronization is enabled, the block passes the echo through a synchronizer and checks where its rising edge lands within each output period. If the edge is late or missing, the block drops one whole output period by holding the clock low for a full period. It does this again until the echo lines up. A busy flag tells software that realignment is in progress.

Top module: `pclk_gen`

## Requirements
- R1: While reset is asserted `pclk_out` and `resync_busy` are low. The ratio after reset is 8, and the first period after reset release starts with 4 high cycles followed by 4 low cycles.
- R2: A write with `div_we` high loads the 3-bit `div_sel` field. A value v selects division of the system clock by v+1.
- R3: A written ratio is applied at the next period boundary. A write sampled on the edge that ends a period governs the period that starts at that edge. The last written value wins.
- R4: Every output period starts with its high phase. For ratio N ≥ 2 the clock is high for floor(N/2) system cycles and low for the remaining cycles. Even ratios therefore give 50% duty, and for odd ratios the high phase is one cycle shorter than the low phase.
- R5: At ratio 1, `pclk_out` follows the system clock.
- R6: The echo passes through a two-stage synchronizer. With resync enabled and ratio ≥ 2, an echo equal to `pclk_out` delayed by less than one system cycle is aligned: no period is skipped and `resync_busy` stays low.
- R7: With resync enabled and ratio ≥ 2, a period in which the synchronized echo does not rise exactly 2 mod N cycles after the period start counts as misaligned. The following period is skipped: the output stays low for one full period, so the low run is ceil(N/2)+N cycles.
- R8: `resync_busy` rises at the start of a skipped period. The period after a skip, or after a ratio change, is not judged. The flag falls at the end of the second consecutive judged period that is aligned. For N=4 with a single skip, this keeps the flag high for 16 cycles.
- R9: With `resync_en` low no period is skipped and `resync_busy` stays low, whatever the echo does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_we | input | 1 | Divide-select write strobe |
| div_sel | input | 3 | Divide select; ratio = value + 1 |
| resync_en | input | 1 | Enables echo monitoring and period skipping |
| echo_clk | input | 1 | Processor clock echoed back by the processor |
| pclk_out | output | 1 | Generated processor clock |
| resync_busy | output | 1 | Realignment in progress |

## Verification
The assertions assume three things about the inputs. The divide select never exceeds the supported maximum. `resync_en` is held steady while a realignment is in progress. The echo is a delayed copy of the generated clock and never a free-running unrelated signal. The bench always produces the echo by delaying `pclk_out` through a short history register, with a delay of 0 to 3 cycles. Resync is enabled only after the ratio has settled, and left alone until the busy flag has cleared. Random divide writes are confined to the 3-bit field.

// File: rtl/pclk_gen_pkg.sv
package pclk_gen_pkg;

   // Cycle within a period at which a synchronized, in-phase echo rises.
   function automatic int unsigned echo_offset(int unsigned lag, int unsigned ratio);
      return (ratio == 0) ? 0 : (lag % ratio);
   endfunction

   // Supported ratio bound must be a power of two so select and counter share a width.
   function automatic bit is_pow2(int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/pclk_sync.sv
module pclk_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("pclk_sync: STAGES must be at least 2");
   end

   for (genvar i = 0; i < STAGES; i++) begin : g_st
      logic s;
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) s <= 1'b0;
            else        s <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) s <= 1'b0;
            else        s <= g_st[i-1].s;
         end
      end
   end

   assign q = g_st[STAGES-1].s;

endmodule

// File: rtl/pclk_div_core.sv
module pclk_div_core #(
   parameter int MAX_DIV   = 8,
   parameter int RESET_DIV = 8,
   localparam int CNT_W    = $clog2(MAX_DIV),
   localparam int RAT_W    = CNT_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [CNT_W-1:0] wr_sel,
   input  logic             skip,
   output logic [CNT_W-1:0] cnt_o,
   output logic [RAT_W-1:0] ratio_o,
   output logic [RAT_W-1:0] ratio_nxt_o,
   output logic             boundary_o,
   output logic             level_o
);

   logic [CNT_W-1:0] cnt_q;
   logic [RAT_W-1:0] ratio_q, pend_q, pend_nxt;
   logic [RAT_W-1:0] cnt_x;

   assign cnt_x      = {1'b0, cnt_q};
   assign pend_nxt   = wr_en ? (RAT_W'(wr_sel) + RAT_W'(1)) : pend_q;
   assign boundary_o = (cnt_x == (ratio_q - RAT_W'(1)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= CNT_W'(RESET_DIV - 1);
         ratio_q <= RAT_W'(RESET_DIV);
         pend_q  <= RAT_W'(RESET_DIV);
      end else begin
         pend_q <= pend_nxt;
         if (boundary_o) begin
            cnt_q   <= '0;
            ratio_q <= pend_nxt;
         end else begin
            cnt_q <= cnt_q + CNT_W'(1);
         end
      end
   end

   assign level_o     = ~skip & (ratio_q > RAT_W'(1)) & (cnt_x < (ratio_q >> 1));
   assign cnt_o       = cnt_q;
   assign ratio_o     = ratio_q;
   assign ratio_nxt_o = pend_nxt;

endmodule

// File: rtl/pclk_phase_mon.sv
module pclk_phase_mon
   import pclk_gen_pkg::*;
#(
   parameter int CNT_W        = 3,
   parameter int SYNC_STAGES  = 2,
   parameter int GOOD_PERIODS = 2,
   localparam int RAT_W       = CNT_W + 1,
   localparam int GOOD_W      = $clog2(GOOD_PERIODS + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             echo_s,
   input  logic             resync_en,
   input  logic [CNT_W-1:0] cnt,
   input  logic [RAT_W-1:0] ratio,
   input  logic [RAT_W-1:0] ratio_nxt,
   input  logic             boundary,
   output logic             skip_o,
   output logic             busy_o
);

   logic              prev_q, seen_q, eval_q, skip_q, busy_q;
   logic [GOOD_W-1:0] good_q;
   logic [CNT_W-1:0]  exp_off;
   logic              rise, at_off, hit, judge, miss;

   assign exp_off = CNT_W'(echo_offset(SYNC_STAGES, ratio));
   assign rise    = echo_s & ~prev_q;
   assign at_off  = rise & (cnt == exp_off);
   assign hit     = seen_q | at_off;
   assign judge   = boundary & eval_q & ~skip_q & resync_en & (ratio > RAT_W'(1));
   assign miss    = judge & ~hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         seen_q <= 1'b0;
         eval_q <= 1'b0;
         skip_q <= 1'b0;
         busy_q <= 1'b0;
         good_q <= '0;
      end else begin
         prev_q <= echo_s;
         if (boundary) begin
            seen_q <= 1'b0;
            skip_q <= miss;
            eval_q <= ~skip_q & ~miss & (ratio_nxt == ratio);
            if (miss) begin
               busy_q <= 1'b1;
               good_q <= '0;
            end else if (judge && busy_q) begin
               if (good_q == GOOD_W'(GOOD_PERIODS - 1)) begin
                  busy_q <= 1'b0;
                  good_q <= '0;
               end else begin
                  good_q <= good_q + GOOD_W'(1);
               end
            end
         end else begin
            seen_q <= hit;
         end
      end
   end

   assign skip_o = skip_q;
   assign busy_o = busy_q;

endmodule

// File: rtl/pclk_gen.sv
module pclk_gen
   import pclk_gen_pkg::*;
#(
   parameter int MAX_DIV      = 8,
   parameter int RESET_DIV    = 8,
   parameter int SYNC_STAGES  = 2,
   parameter int GOOD_PERIODS = 2,
   parameter bit BYPASS_DIV1  = 1'b1,
   localparam int CNT_W       = $clog2(MAX_DIV),
   localparam int RAT_W       = CNT_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             div_we,
   input  logic [CNT_W-1:0] div_sel,
   input  logic             resync_en,
   input  logic             echo_clk,
   output logic             pclk_out,
   output logic             resync_busy
);

   if (!is_pow2(MAX_DIV) || MAX_DIV < 2) begin : g_bad_max
      $error("pclk_gen: MAX_DIV must be a power of two of at least 2");
   end
   if (RESET_DIV < 1 || RESET_DIV > MAX_DIV) begin : g_bad_reset
      $error("pclk_gen: RESET_DIV out of range");
   end
   if (GOOD_PERIODS < 1) begin : g_bad_good
      $error("pclk_gen: GOOD_PERIODS must be at least 1");
   end

   logic [CNT_W-1:0] cnt;
   logic [RAT_W-1:0] ratio, ratio_nxt;
   logic             boundary, level, skip, echo_s;

   pclk_div_core #(
      .MAX_DIV  (MAX_DIV),
      .RESET_DIV(RESET_DIV)
   ) u_core (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (div_we),
      .wr_sel     (div_sel),
      .skip       (skip),
      .cnt_o      (cnt),
      .ratio_o    (ratio),
      .ratio_nxt_o(ratio_nxt),
      .boundary_o (boundary),
      .level_o    (level)
   );

   pclk_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (echo_clk),
      .q    (echo_s)
   );

   pclk_phase_mon #(
      .CNT_W       (CNT_W),
      .SYNC_STAGES (SYNC_STAGES),
      .GOOD_PERIODS(GOOD_PERIODS)
   ) u_mon (
      .clk      (clk),
      .rst_n    (rst_n),
      .echo_s   (echo_s),
      .resync_en(resync_en),
      .cnt      (cnt),
      .ratio    (ratio),
      .ratio_nxt(ratio_nxt),
      .boundary (boundary),
      .skip_o   (skip),
      .busy_o   (resync_busy)
   );

   if (BYPASS_DIV1) begin : g_bypass
      assign pclk_out = level | (clk & ~skip & (ratio == RAT_W'(1)));
   end else begin : g_nobypass
      assign pclk_out = level;
   end

endmodule

// File: rtl/pclk_gen_chk.sv
module pclk_gen_chk #(
   parameter int RAT_W     = 4,
   parameter int RESET_DIV = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             resync_en,
   input logic             pclk_out,
   input logic             busy,
   input logic             skip,
   input logic             boundary,
   input logic [RAT_W-1:0] ratio
);

   AST_RESET_RATIO: assert property (@(posedge clk)
      $rose(rst_n) |-> (ratio == RAT_W'(RESET_DIV)));                             // R1

   AST_RATIO_AT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ratio) |-> $past(boundary));                                       // R3

   AST_PERIOD_ENDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (boundary && ratio > RAT_W'(1)) |-> !pclk_out);                             // R4

   AST_SKIP_HOLDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (skip && ratio > RAT_W'(1)) |-> !pclk_out);                                 // R7

   AST_SKIP_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(skip) |-> ($past(resync_en) && $past(ratio) > RAT_W'(1)));            // R9

   AST_BUSY_IN_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
      skip |-> busy);                                                             // R8

endmodule

bind pclk_gen pclk_gen_chk #(
   .RAT_W    (RAT_W),
   .RESET_DIV(RESET_DIV)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .resync_en(resync_en),
   .pclk_out (pclk_out),
   .busy     (resync_busy),
   .skip     (skip),
   .boundary (boundary),
   .ratio    (ratio)
);

// File: tb/pclk_gen_tb.sv
module pclk_gen_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       div_we = 1'b0;
   logic [2:0] div_sel = 3'd0;
   logic       resync_en = 1'b0;
   logic       echo_clk = 1'b0;
   wire        pclk_out;
   wire        resync_busy;

   int n_checks = 0;
   int n_fail   = 0;

   // bench reference of the divider
   int   m_cnt = 7, m_ratio = 8, m_pend = 8;
   bit   ref_on = 1'b0, idle_chk = 1'b0;
   int   dly = 0;
   logic [7:0] hist = 8'd0;
   int   low_run = 0, max_low = 0;

   always #5 clk = ~clk;

   pclk_gen u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .div_we     (div_we),
      .div_sel    (div_sel),
      .resync_en  (resync_en),
      .echo_clk   (echo_clk),
      .pclk_out   (pclk_out),
      .resync_busy(resync_busy)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
   endtask

   // One system cycle: called at a negedge with inputs already set.
   task automatic tick();
      bit w = div_we;
      int s = int'(div_sel);
      int pn, exp_lvl;
      @(posedge clk);
      #2;
      if (ref_on && m_ratio == 1 && m_pend == 1 && !w)
         chk(pclk_out == 1'b1, "R5 high phase", int'(pclk_out), 1);
      @(negedge clk);
      pn = w ? s + 1 : m_pend;
      m_pend = pn;
      if (m_cnt == m_ratio - 1) begin
         m_cnt = 0;
         m_ratio = pn;
      end else begin
         m_cnt++;
      end
      exp_lvl = (m_ratio >= 2 && m_cnt < m_ratio / 2) ? 1 : 0;
      if (ref_on)
         chk(int'(pclk_out) == exp_lvl, "R2,R3,R4 level", int'(pclk_out), exp_lvl);
      if (idle_chk)
         chk(resync_busy == 1'b0, "R9 busy idle", int'(resync_busy), 0);
      if (pclk_out == 1'b0) low_run++;
      else low_run = 0;
      if (low_run > max_low) max_low = low_run;
      hist = {hist[6:0], pclk_out};
      echo_clk = hist[dly];
   endtask

   task automatic write_sel(input int v);
      div_we  = 1'b1;
      div_sel = 3'(v);
      tick();
      div_we  = 1'b0;
   endtask

   initial begin
      #2_000_000;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
      $finish;
   end

   initial begin
      int busy_cycles;
      bit seen;
      void'($urandom(32'h5EED_0C1C));

      // R1: reset state
      repeat (3) begin
         @(negedge clk);
         chk(pclk_out == 1'b0, "R1 reset pclk", int'(pclk_out), 0);
         chk(resync_busy == 1'b0, "R1 reset busy", int'(resync_busy), 0);
      end
      rst_n  = 1'b1;
      ref_on = 1'b1;

      // R1, R4: reset ratio of 8, then a mid-period write (R3)
      repeat (11) tick();
      write_sel(3);                        // R2: value 3 selects divide by 4
      repeat (12) tick();

      // R3: write in the final cycle of a period
      while (m_cnt != m_ratio - 1) tick();
      write_sel(4);                        // divide by 5, applies at once
      chk(m_ratio == 5, "R3 boundary write", m_ratio, 5);
      repeat (15) tick();

      // R3: last of two writes wins
      write_sel(6);
      write_sel(2);
      repeat (20) tick();

      // R4: odd ratios
      write_sel(6); repeat (22) tick();
      write_sel(1); repeat (12) tick();

      // R5: divide by 1
      write_sel(0); repeat (12) tick();

      // R9 and random ratio changes with resync off and skewed echo
      idle_chk = 1'b1;
      for (int i = 0; i < 500; i++) begin
         if ($urandom_range(0, 11) == 0) dly = $urandom_range(0, 3);
         if ($urandom_range(0, 9) == 0) write_sel($urandom_range(0, 7));
         else tick();
      end
      idle_chk = 1'b0;

      // R6: aligned echo, divide by 4
      dly = 0;
      write_sel(3);
      repeat (20) tick();
      resync_en = 1'b1;
      for (int i = 0; i < 48; i++) begin
         tick();
         chk(resync_busy == 1'b0, "R6 aligned busy", int'(resync_busy), 0);
      end

      // R7: late echo forces a skip
      ref_on  = 1'b0;
      max_low = 0;
      low_run = 0;
      dly     = 1;
      seen    = 1'b0;
      for (int i = 0; i < 60 && !seen; i++) begin
         tick();
         if (resync_busy) seen = 1'b1;
      end
      chk(seen, "R7 skip reported", int'(seen), 1);
      chk(pclk_out == 1'b0, "R8 busy during skip", int'(pclk_out), 0);
      dly = 0;

      // R8: busy clears after two judged aligned periods
      busy_cycles = 1;
      for (int i = 0; i < 60 && resync_busy; i++) begin
         tick();
         if (resync_busy) busy_cycles++;
      end
      chk(resync_busy == 1'b0, "R8 busy cleared", int'(resync_busy), 0);
      chk(busy_cycles == 16, "R8 busy length", busy_cycles, 16);
      chk(max_low == 6, "R7 skipped low run", max_low, 6);

      // R6: stays aligned afterwards
      for (int i = 0; i < 24; i++) begin
         tick();
         chk(resync_busy == 1'b0, "R6 realigned", int'(resync_busy), 0);
      end

      summary();
      $finish;
   end

endmodule